// File: doc/BRIEF.md
# Multi-Source Reset Controller with Cause Record

This block merges every reset request of the chip into one system reset. It accepts seven requests. Four are asynchronous fault and pin flags: an external reset pin, a watchdog timeout, PLL lock lost and PLL clock lost. Software can raise a request through a control register. A low-voltage flag also counts as a request, but only when software has enabled it. A power-on input resets the controller itself. The asynchronous flags are resynchronized. The system reset output rises as soon as any request is seen. It falls a fixed number of cycles after the last request has gone away.

Alongside the reset, the block keeps a record of what caused it. When a reset episode starts from a quiet state, the record is replaced by the set of requests active at that moment. Requests that join while the episode is still active are added to the record. Power-on overrides everything else and leaves only its own bit. Software reads the record through a small register port, where it also finds the control register.

Top module: `reset_cause_ctrl`

## Requirements
- R1: The cause register has one bit per source: bit0 power-on, bit1 external pin, bit2 watchdog, bit3 PLL lock lost, bit4 PLL clock lost, bit5 software, bit6 low voltage. Bit7 always reads 0.
- R2: An asynchronous request driven high before clock edge A is still not visible on `sys_rst` after edge A. `sys_rst` is high after edge A+2.
- R3: `sys_rst` stays high while any request is active. With SYNC_STAGES=2 it falls at the HOLD_CYCLES+3rd rising edge counted from the last raw request going low, or from the end of a software write.
- R4: When a request appears and no request was active in the previous cycle, the cause register is replaced by exactly the set of active requests.
- R5: A request that becomes active while another request is still active is added to the cause register.
- R6: While power-on is active, the cause register holds 0x01, even if other requests are present at the same time.
- R7: Writing 1 to control bit0 (address 0) starts a software reset. The bit reads back as 1 until the reset output has been seen high, then it clears by itself.
- R8: Control bit1 (address 0) enables the low-voltage flag. While this bit is 0 the flag has no effect on `sys_rst` or on the cause register.
- R9: `reg_rdata` is combinational: address 0 returns {6'b0, lvd enable, software pending} and address 1 returns the cause. While power-on is asserted, `sys_rst` is 1, the cause reads 0x01 and the control register reads 0x00.
- R10: Between reset episodes the cause register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| por_req | input | 1 | Power-on request; asynchronously resets the controller |
| ext_req | input | 1 | External reset pin request, asynchronous |
| wdog_req | input | 1 | Watchdog timeout request, asynchronous |
| lol_req | input | 1 | PLL lock-lost request, asynchronous |
| loc_req | input | 1 | PLL clock-lost request, asynchronous |
| lvd_flag | input | 1 | Low-voltage flag, asynchronous, acts only when enabled |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 cause |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data |
| sys_rst | output | 1 | Stretched system reset, active high |

## Verification
The bench builds the block with HOLD_CYCLES=5, SYNC_STAGES=2 and DATA_W=8. The short hold lets the bench predict the exact release edge of every episode and still run dozens of random episodes within its cycle budget. The scenarios include overlapping sources, episodes that replace the previous cause, software and low-voltage requests, and power-on together with other sources. Two synchronizer stages make the assert latency and the release latency fixed numbers that the bench can compare against.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int NUM_CAUSE = 7;
  localparam int CB_POR  = 0;
  localparam int CB_EXT  = 1;
  localparam int CB_WDOG = 2;
  localparam int CB_LOL  = 3;
  localparam int CB_LOC  = 4;
  localparam int CB_SW   = 5;
  localparam int CB_LVD  = 6;

  typedef logic [NUM_CAUSE-1:0] cause_t;
  localparam cause_t CAUSE_POR_ONLY = cause_t'(1) << CB_POR;

  localparam logic REG_CTRL  = 1'b0;
  localparam logic REG_CAUSE = 1'b1;
  localparam int CTRL_SW_BIT  = 0;
  localparam int CTRL_LVD_BIT = 1;
endpackage

// File: rtl/rstc_sync.sv
// Multi-stage synchronizer; reset value chosen by parameter
module rstc_sync #(
  parameter int   WIDTH   = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             arst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) chain_q <= {(STAGES*WIDTH){RST_VAL}};
    else      chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rstc_cause.sv
// Cause record: replace on a fresh episode, accumulate during one, POR wins
module rstc_cause
  import rstc_pkg::*;
(
  input  logic   clk,
  input  logic   por_arst,
  input  cause_t req,
  output cause_t cause
);
  logic any_req;
  logic prev_any_q;

  assign any_req = |req;

  always_ff @(posedge clk or posedge por_arst) begin
    if (por_arst) begin
      cause      <= CAUSE_POR_ONLY;
      prev_any_q <= 1'b1;
    end else begin
      prev_any_q <= any_req;
      if (req[CB_POR])               cause <= CAUSE_POR_ONLY;
      else if (any_req && !prev_any_q) cause <= req;
      else if (any_req)              cause <= cause | req;
    end
  end
endmodule

// File: rtl/rstc_stretch.sv
// Hold counter: reloaded while any request is present, output registered
module rstc_stretch #(
  parameter int HOLD_CYCLES = 16
) (
  input  logic clk,
  input  logic por_arst,
  input  logic any_req,
  output logic sys_rst
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or posedge por_arst) begin
    if (por_arst) begin
      cnt_q   <= HOLD_LD;
      sys_rst <= 1'b1;
    end else begin
      if (any_req)            cnt_q <= HOLD_LD;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      sys_rst <= any_req || (cnt_q != '0);
    end
  end
endmodule

// File: rtl/rstc_regs.sv
// Control register (software request, low-voltage enable) and read mux
module rstc_regs
  import rstc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              por_arst,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              sys_rst,
  input  cause_t            cause,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              sw_pend,
  output logic              lvd_en
);
  logic ctrl_wr;
  logic unused_wdata;

  assign ctrl_wr      = reg_wr && (reg_addr == REG_CTRL);
  assign unused_wdata = ^reg_wdata[DATA_W-1:2];

  always_ff @(posedge clk or posedge por_arst) begin
    if (por_arst) begin
      sw_pend <= 1'b0;
      lvd_en  <= 1'b0;
    end else begin
      if (ctrl_wr) lvd_en <= reg_wdata[CTRL_LVD_BIT];
      if (ctrl_wr && reg_wdata[CTRL_SW_BIT]) sw_pend <= 1'b1;
      else if (sys_rst)                      sw_pend <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == REG_CTRL) begin
      reg_rdata[CTRL_SW_BIT]  = sw_pend;
      reg_rdata[CTRL_LVD_BIT] = lvd_en;
    end else begin
      reg_rdata[NUM_CAUSE-1:0] = cause;
    end
  end
endmodule

// File: rtl/reset_cause_ctrl.sv
module reset_cause_ctrl
  import rstc_pkg::*;
#(
  parameter int HOLD_CYCLES = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              por_req,
  input  logic              ext_req,
  input  logic              wdog_req,
  input  logic              lol_req,
  input  logic              loc_req,
  input  logic              lvd_flag,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              sys_rst
);
  localparam int ASYNC_W = 5;

  logic               por_q;
  logic [ASYNC_W-1:0] async_raw;
  logic [ASYNC_W-1:0] async_s;
  logic               sw_pend;
  logic               lvd_en;
  cause_t             req_vec;
  cause_t             cause_q;

  // Power-on: asserted asynchronously, released through the synchronizer
  rstc_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_por_sync (
    .clk (clk),
    .arst(por_req),
    .d   (1'b0),
    .q   (por_q)
  );

  assign async_raw = {lvd_flag, loc_req, lol_req, wdog_req, ext_req};

  rstc_sync #(.WIDTH(ASYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_src_sync (
    .clk (clk),
    .arst(por_req),
    .d   (async_raw),
    .q   (async_s)
  );

  always_comb begin
    req_vec          = '0;
    req_vec[CB_POR]  = por_q;
    req_vec[CB_EXT]  = async_s[0];
    req_vec[CB_WDOG] = async_s[1];
    req_vec[CB_LOL]  = async_s[2];
    req_vec[CB_LOC]  = async_s[3];
    req_vec[CB_SW]   = sw_pend;
    req_vec[CB_LVD]  = async_s[4] & lvd_en;
  end

  rstc_cause u_cause (
    .clk     (clk),
    .por_arst(por_req),
    .req     (req_vec),
    .cause   (cause_q)
  );

  rstc_stretch #(.HOLD_CYCLES(HOLD_CYCLES)) u_stretch (
    .clk     (clk),
    .por_arst(por_req),
    .any_req (|req_vec),
    .sys_rst (sys_rst)
  );

  rstc_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .por_arst (por_req),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .sys_rst  (sys_rst),
    .cause    (cause_q),
    .reg_rdata(reg_rdata),
    .sw_pend  (sw_pend),
    .lvd_en   (lvd_en)
  );
endmodule

// File: rtl/reset_cause_ctrl_chk.sv
module reset_cause_ctrl_chk
  import rstc_pkg::*;
#(
  parameter int HOLD_CYCLES = 16
) (
  input logic   clk,
  input logic   por_req,
  input logic   sys_rst,
  input logic   sw_wr,
  input cause_t req_vec,
  input cause_t cause_q,
  input logic   sw_pend
);
  localparam int QW = $clog2(HOLD_CYCLES + 3);
  localparam logic [QW-1:0] QMAX = QW'(HOLD_CYCLES + 2);

  logic [QW-1:0] quiet_q;
  logic          prev_any_q;

  always_ff @(posedge clk or posedge por_req) begin
    if (por_req) begin
      quiet_q    <= '0;
      prev_any_q <= 1'b1;
    end else begin
      prev_any_q <= |req_vec;
      if (|req_vec)           quiet_q <= '0;
      else if (quiet_q != QMAX) quiet_q <= quiet_q + 1'b1;
    end
  end

  // R2: any request drives the reset output on the next edge
  p_rst_on_req_r2: assert property (@(posedge clk) disable iff (por_req)
    (|req_vec) |=> sys_rst);

  // R3: release comes exactly after the hold window
  p_release_hold_r3: assert property (@(posedge clk) disable iff (por_req)
    $fell(sys_rst) |-> (quiet_q == QW'(HOLD_CYCLES + 1)));

  // R4: a fresh episode replaces the record with the active set
  p_fresh_replace_r4: assert property (@(posedge clk) disable iff (por_req)
    ((|req_vec) && !prev_any_q && !req_vec[CB_POR]) |=> (cause_q == $past(req_vec)));

  // R6: power-on leaves only its own bit
  p_por_only_r6: assert property (@(posedge clk) disable iff (por_req)
    req_vec[CB_POR] |=> (cause_q == CAUSE_POR_ONLY));

  // R7: software request clears once reset output is seen
  p_sw_selfclear_r7: assert property (@(posedge clk) disable iff (por_req)
    (sys_rst && !sw_wr) |=> !sw_pend);

  // R10: record is stable while no request is present
  p_cause_kept_r10: assert property (@(posedge clk) disable iff (por_req)
    !(|req_vec) |=> $stable(cause_q));
endmodule

bind reset_cause_ctrl reset_cause_ctrl_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk    (clk),
  .por_req(por_req),
  .sys_rst(sys_rst),
  .sw_wr  (reg_wr && (reg_addr == rstc_pkg::REG_CTRL) && reg_wdata[rstc_pkg::CTRL_SW_BIT]),
  .req_vec(req_vec),
  .cause_q(cause_q),
  .sw_pend(sw_pend)
);

// File: tb/tb_reset_cause_ctrl.sv
module tb_reset_cause_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 5;
  localparam int REL_N      = HOLD + 3;

  logic       clk = 1'b0;
  logic       por_req, ext_req, wdog_req, lol_req, loc_req, lvd_flag;
  logic       reg_wr, reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       sys_rst;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reset_cause_ctrl #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(2), .DATA_W(8)) dut (
    .clk(clk), .por_req(por_req), .ext_req(ext_req), .wdog_req(wdog_req),
    .lol_req(lol_req), .loc_req(loc_req), .lvd_flag(lvd_flag),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sys_rst(sys_rst)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // raw bit order: 0 ext, 1 wdog, 2 lol, 3 loc, 4 lvd
  function automatic logic [7:0] exp_cause(input logic [4:0] raw, input logic en);
    logic [7:0] e;
    e = 8'h00;
    e[1] = raw[0]; e[2] = raw[1]; e[3] = raw[2]; e[4] = raw[3];
    e[6] = raw[4] & en;
    return e;
  endfunction

  task automatic drive_raw(input logic [4:0] raw);
    {lvd_flag, loc_req, lol_req, wdog_req, ext_req} = raw;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic wait_release(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (sys_rst && n < 200);
  endtask

  // one episode from idle; returns expected raw union
  task automatic episode(input logic [4:0] m1, input logic [4:0] m2, input int k1,
                         input int k2, input logic en, input string tag);
    int n;
    logic [7:0] d;
    @(negedge clk);
    drive_raw(m1);
    @(negedge clk);
    chk({tag, " R2 early"}, sys_rst, 1'b0);
    repeat (2) @(negedge clk);
    chk({tag, " R2 asserted"}, sys_rst, 1'b1);
    repeat (k1) @(negedge clk);
    if (m2 != 5'b0) begin
      drive_raw(m1 | m2);
      repeat (k2 + 1) @(negedge clk);
    end
    drive_raw(5'b0);
    wait_release(n);
    chk({tag, " R3 release"}, n, REL_N);
    rd(1'b1, d);
    chk({tag, (m2 != 5'b0) ? " R5 cause" : " R4 cause"}, d, exp_cause(m1 | m2, en));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] d, prev;
    void'($urandom(32'd4711));
    por_req = 1'b1; drive_raw(5'b0);
    reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = 8'h00;
    repeat (3) @(negedge clk);

    // R9 reset state
    chk("R9 sys_rst in por", sys_rst, 1'b1);
    rd(1'b1, d); chk("R9 cause in por", d, 8'h01);
    rd(1'b0, d); chk("R9 ctrl in por", d, 8'h00);

    // R6: other sources during power-on are dropped from the record
    drive_raw(5'b00011);
    repeat (3) @(negedge clk);
    por_req = 1'b0; drive_raw(5'b0);
    wait_release(n);
    chk("R3 release after por", n, REL_N);
    rd(1'b1, d); chk("R6 por only", d, 8'h01);

    // R1: each async source alone sets its own bit
    for (int b = 0; b < 4; b++) episode(5'(1 << b), 5'b0, 2, 0, 1'b0, "R1 single");

    // R4: new episode replaces the previous cause
    episode(5'b00001, 5'b0, 1, 0, 1'b0, "R4 first");
    episode(5'b01000, 5'b0, 3, 0, 1'b0, "R4 second");

    // R5: overlapping sources accumulate
    episode(5'b00010, 5'b00100, 2, 2, 1'b0, "R5 overlap");

    // R7 software reset
    wr_ctrl(8'h01);
    wait_release(n);
    chk("R7 sw release", n, REL_N);
    rd(1'b1, d); chk("R7 sw cause", d, 8'h20);
    rd(1'b0, d); chk("R7 sw selfclear", d, 8'h00);

    // R8 disabled low-voltage flag is ignored
    lvd_flag = 1'b1;
    repeat (8) @(negedge clk);
    chk("R8 lvd disabled no reset", sys_rst, 1'b0);
    rd(1'b1, d); chk("R8 lvd disabled cause kept", d, 8'h20);
    lvd_flag = 1'b0;
    repeat (3) @(negedge clk);

    // R8 enabled low-voltage flag
    wr_ctrl(8'h02);
    rd(1'b0, d); chk("R9 ctrl readback", d, 8'h02);
    episode(5'b10000, 5'b0, 2, 0, 1'b1, "R8 lvd enabled");
    wr_ctrl(8'h00);

    // random episodes with idle gaps
    rd(1'b1, prev);
    for (int i = 0; i < 30; i++) begin
      logic [4:0] m1, m2;
      int gap;
      m1 = 5'(($urandom % 15) + 1);
      m2 = (($urandom % 10) < 3) ? 5'(($urandom % 15) + 1) : 5'b0;
      gap = $urandom % 4;
      repeat (gap) @(negedge clk);
      rd(1'b1, d); chk("R10 cause held", d, prev);
      episode(m1, m2, $urandom % 4, $urandom % 3, 1'b0, "rand");
      rd(1'b1, prev);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule